// File: doc/BRIEF.md
# Fixed-Window Modular Exponentiator

This block raises a base to an exponent modulo a modulus, `base^exponent mod modulus`, for small parameterized operand widths. It uses the m-ary fixed-window method. When a request is accepted, it first fills a table with the powers `base^0 .. base^(2^WIN - 1)`, each reduced by the modulus. It then treats the exponent as a string of WIN-bit digits and handles them from the top digit down. For each digit the accumulator is squared WIN times and then multiplied by the table entry that the digit selects.

All arithmetic goes through one bit-serial modular multiplier. The multiplier consumes one bit of its second operand per clock and folds the reduction into each step. It keeps no full double-width product. A zero digit still costs a multiply, by table entry 0, which holds 1. As a result, the number of cycles from start to done is the same for every exponent and every operand value.

The caller raises `start` for one cycle while the engine is idle. It then waits for the one-cycle `done` pulse and reads `result`. The caller must supply a modulus greater than 1 and a base smaller than the modulus.

Top module: `fixed_window_modexp`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `result` is 0.
- R2: The power table is filled so that entry 0 is 1 and entry j (1 to 2^WIN-1) equals entry j-1 times the base, reduced by the modulus. An exponent below 2^WIN therefore returns `base^exponent mod modulus`.
- R3: The exponent is zero-extended to ceil(EW/WIN)*WIN bits and cut into WIN-bit digits. The digits are consumed from the most significant one down, and the top digit may be partly padding.
- R4: The accumulator starts at 1. For each digit it is squared WIN times and then multiplied by the table entry indexed by that digit, so `result` equals `base^exponent mod modulus`.
- R5: An exponent of 0 yields 1, including for base 0. Base 0 with a non-zero exponent yields 0.
- R6: Every square and every multiply is reduced, so each multiplier product and the final result are smaller than the modulus. This includes the smallest legal modulus, 2, and a base of modulus-1.
- R7: The number of cycles from an accepted `start` to `done` is identical for all exponents, bases and moduli.
- R8: `done` is high for exactly one cycle. In that cycle `busy` has just fallen. `result` then holds its value until the next accepted `start`.
- R9: A `start` pulse while `busy` is high is ignored. The operation in progress finishes with its own operands and produces exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; operands sampled when accepted |
| base | input | N | Base, must be below modulus |
| modulus | input | N | Modulus, must be greater than 1 |
| exponent | input | EW | Exponent |
| busy | output | 1 | High while an operation is running |
| done | output | 1 | One-cycle pulse when result is valid |
| result | output | N | `base^exponent mod modulus` |

## Verification
Small exponents below the table size return individual table entries, which isolates the fill step from the digit walk. Exponents with only the padded top digit set, all bits set, and sparse bit patterns separate errors in digit slicing and digit order from errors in the square count. Zero exponent, zero base, a modulus of 2 and a base of modulus-1 probe the reduction boundaries. A mix of pseudo-random operands, each timed from start to done, shows that the cycle count does not move with the exponent. A start pulse injected mid-operation shows that new operands are ignored while the engine is busy.

// File: rtl/fwexp_pkg.sv
package fwexp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_WALK = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mod_mul_serial.sv
// Bit-serial interleaved modular multiplier: opa*opb mod m, one opb bit per
// cycle from the MSB. Requires opa, opb < m and m > 1.
module mod_mul_serial #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic [N-1:0] modulus,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] product
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] acc_q, acc_d, a_q, a_d, b_q, b_d, m_q, m_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic busy_q, busy_d, done_q, done_d;
  logic [N:0] dbl, dbl_r, sum, sum_r, m_ext;

  always_comb begin
    m_ext = {1'b0, m_q};
    dbl   = {acc_q, 1'b0};
    dbl_r = (dbl >= m_ext) ? (dbl - m_ext) : dbl;
    sum   = dbl_r + {1'b0, a_q};
    sum_r = (sum >= m_ext) ? (sum - m_ext) : sum;
  end

  always_comb begin
    acc_d  = acc_q;
    a_d    = a_q;
    b_d    = b_q;
    m_d    = m_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (!busy_q && go) begin
      acc_d  = '0;
      a_d    = opa;
      b_d    = opb;
      m_d    = modulus;
      cnt_d  = CW'(N - 1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      acc_d = b_q[N-1] ? sum_r[N-1:0] : dbl_r[N-1:0];
      b_d   = {b_q[N-2:0], 1'b0};
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      m_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      a_q    <= a_d;
      b_q    <= b_d;
      m_q    <= m_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = acc_q;
endmodule

// File: rtl/power_table.sv
// Register file holding base^0 .. base^(2^AW-1), one write and one read port.
module power_table #(
  parameter int N  = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [N-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [N-1:0]  rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [N-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[e] <= '0;
      else if (hit) mem[e] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fixed_window_modexp.sv
module fixed_window_modexp
  import fwexp_pkg::*;
#(
  parameter int N   = 16,
  parameter int EW  = 16,
  parameter int WIN = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [N-1:0]  base,
  input  logic [N-1:0]  modulus,
  input  logic [EW-1:0] exponent,
  output logic          busy,
  output logic          done,
  output logic [N-1:0]  result
);
  localparam int ND  = (EW + WIN - 1) / WIN;
  localparam int PW  = ND * WIN;
  localparam int DW  = (ND > 1) ? $clog2(ND) : 1;
  localparam int OPW = $clog2(WIN + 1);

  seq_state_e state_q, state_d;
  logic [WIN-1:0] idx_q, idx_d;
  logic [DW-1:0]  dig_q, dig_d;
  logic [OPW-1:0] op_q, op_d;
  logic           pend_q, pend_d;
  logic           done_q, done_d;
  logic [N-1:0]   acc_q, acc_d;
  logic [N-1:0]   base_q, mod_q;
  logic [PW-1:0]  exp_q;
  logic           ld;

  logic           mul_go, mul_busy, mul_done;
  logic [N-1:0]   mul_a, mul_b, mul_p;
  logic           tbl_we;
  logic [WIN-1:0] tbl_waddr, tbl_raddr;
  logic [N-1:0]   tbl_wdata, tbl_rdata;
  logic [WIN-1:0] digit;

  assign digit = exp_q[int'(dig_q) * WIN +: WIN];
  assign ld    = (state_q == ST_IDLE) && start;

  mod_mul_serial #(.N(N)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_go), .opa(mul_a), .opb(mul_b),
    .modulus(mod_q), .busy(mul_busy), .done(mul_done), .product(mul_p)
  );

  power_table #(.N(N), .AW(WIN)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_addr(tbl_waddr),
    .wr_data(tbl_wdata), .rd_addr(tbl_raddr), .rd_data(tbl_rdata)
  );

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    dig_d     = dig_q;
    op_d      = op_q;
    pend_d    = pend_q;
    acc_d     = acc_q;
    done_d    = 1'b0;
    mul_go    = 1'b0;
    mul_a     = acc_q;
    mul_b     = acc_q;
    tbl_we    = 1'b0;
    tbl_waddr = idx_q;
    tbl_wdata = mul_p;
    tbl_raddr = digit;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d   = ST_FILL;
          idx_d     = WIN'(1);
          pend_d    = 1'b0;
          acc_d     = N'(1);
          tbl_we    = 1'b1;
          tbl_waddr = '0;
          tbl_wdata = N'(1);
        end
      end
      ST_FILL: begin
        tbl_raddr = idx_q - WIN'(1);
        if (!pend_q) begin
          mul_go = 1'b1;
          mul_a  = tbl_rdata;
          mul_b  = base_q;
          pend_d = 1'b1;
        end else if (mul_done) begin
          tbl_we = 1'b1;
          pend_d = 1'b0;
          if (&idx_q) begin
            state_d = ST_WALK;
            dig_d   = DW'(ND - 1);
            op_d    = '0;
          end else begin
            idx_d = idx_q + WIN'(1);
          end
        end
      end
      ST_WALK: begin
        if (!pend_q) begin
          mul_go = 1'b1;
          mul_a  = acc_q;
          mul_b  = (op_q == OPW'(WIN)) ? tbl_rdata : acc_q;
          pend_d = 1'b1;
        end else if (mul_done) begin
          acc_d  = mul_p;
          pend_d = 1'b0;
          if (op_q == OPW'(WIN)) begin
            op_d = '0;
            if (dig_q == '0) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else begin
              dig_d = dig_q - DW'(1);
            end
          end else begin
            op_d = op_q + OPW'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      dig_q   <= '0;
      op_q    <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      acc_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      dig_q   <= dig_d;
      op_q    <= op_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
      acc_q   <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mod_q  <= '0;
      exp_q  <= '0;
    end else if (ld) begin
      base_q <= base;
      mod_q  <= modulus;
      exp_q  <= PW'(exponent);
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign result = acc_q;
endmodule

// File: rtl/fwexp_checker.sv
module fwexp_checker #(
  parameter int N   = 16,
  parameter int EW  = 16,
  parameter int WIN = 5
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               start,
  input logic                               busy,
  input logic                               done,
  input logic [N-1:0]                       result,
  input logic [N-1:0]                       mod_q,
  input logic [((EW + WIN - 1) / WIN)*WIN-1:0] exp_q,
  input logic                               mul_done,
  input logic [N-1:0]                       mul_p
);
  logic [19:0] lat_cnt, lat_ref;
  logic        lat_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt  <= '0;
      lat_ref  <= '0;
      lat_seen <= 1'b0;
    end else begin
      if (!busy && start) lat_cnt <= '0;
      else                lat_cnt <= lat_cnt + 20'd1;
      if (done && !lat_seen) begin
        lat_seen <= 1'b1;
        lat_ref  <= lat_cnt;
      end
    end
  end

  assert_reduced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mul_done |-> (mul_p < mod_q));
  assert_result_reduced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < mod_q));
  assert_const_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lat_seen) |-> (lat_cnt == lat_ref));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(result));
  assert_operands_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(exp_q) && $stable(mod_q)));
endmodule

bind fixed_window_modexp fwexp_checker #(.N(N), .EW(EW), .WIN(WIN)) u_fwexp_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .result(result), .mod_q(mod_q), .exp_q(exp_q), .mul_done(mul_done),
  .mul_p(mul_p)
);

// File: tb/test_fixed_window_modexp.sv
module test_fixed_window_modexp;
  localparam int N = 16, EW = 16, WIN = 5;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N-1:0]  base = '0, modulus = 16'd3;
  logic [EW-1:0] exponent = '0;
  logic          busy, done;
  logic [N-1:0]  result;

  int errors = 0, checks = 0, cyc = 0, n_sent = 0, n_seen = 0;
  int ref_lat = -1;
  bit finished = 0;
  logic [N-1:0] q_exp[$];
  string        q_tag[$];
  int           q_t0[$];
  logic [N-1:0] last_exp;
  logic [31:0]  rng = 32'h1234_5678;

  fixed_window_modexp #(.N(N), .EW(EW), .WIN(WIN)) i_fixed_window_modexp (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .modulus(modulus),
    .exponent(exponent), .busy(busy), .done(done), .result(result)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [N-1:0] ref_pow(logic [N-1:0] b, logic [N-1:0] m,
                                           logic [EW-1:0] e);
    longint r = 1;
    for (int i = EW - 1; i >= 0; i--) begin
      r = (r * r) % longint'(m);
      if (e[i]) r = (r * longint'(b)) % longint'(m);
    end
    return N'(r);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard on each done pulse (R4, R7)
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_exp.size() == 0) begin
        check(0, "R9 unexpected done", 1, 0);
      end else begin
        logic [N-1:0] e;
        string t;
        int lat;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        lat = cyc - q_t0.pop_front();
        last_exp = e;
        check(result == e, t, result, e);
        if (ref_lat < 0) ref_lat = lat;
        else check(lat == ref_lat, "R7 latency", lat, ref_lat);
      end
      n_seen++;
    end
  end

  task automatic push_start(logic [N-1:0] b, logic [N-1:0] m, logic [EW-1:0] e,
                            string tag);
    @(negedge clk);
    base = b; modulus = m; exponent = e; start = 1'b1;
    q_exp.push_back(ref_pow(b, m, e));
    q_tag.push_back(tag);
    q_t0.push_back(cyc);
    n_sent++;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (n_seen != n_sent) @(negedge clk);
  endtask

  task automatic run_op(logic [N-1:0] b, logic [N-1:0] m, logic [EW-1:0] e,
                        string tag);
    push_start(b, m, e, tag);
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(result == '0, "R1 result", result, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: exponents below the table size read single entries
    run_op(16'd7, 16'd40009, 16'd1, "R2 e=1");
    run_op(16'd7, 16'd40009, 16'd2, "R2 e=2");
    run_op(16'd7, 16'd40009, 16'd31, "R2 e=31");
    // R3: padded top digit and digit order
    run_op(16'd54321, 16'd60001, 16'h8000, "R3 top digit only");
    run_op(16'd54321, 16'd60001, 16'h7FFF, "R3 low digits");
    run_op(16'd11, 16'd65521, 16'h0021, "R3 digit order");
    // R4: general exponents
    run_op(16'd12345, 16'd65521, 16'hBEEF, "R4 mixed");
    run_op(16'd3, 16'd65535, 16'hFFFF, "R4 all ones");
    run_op(16'd2, 16'd64007, 16'h0421, "R4 sparse");
    // R5: zero exponent and zero base
    run_op(16'd999, 16'd1013, 16'd0, "R5 exp 0");
    run_op(16'd0, 16'd1013, 16'd5, "R5 base 0");
    run_op(16'd0, 16'd1013, 16'd0, "R5 base 0 exp 0");
    // R6: reduction edges
    run_op(16'd1, 16'd2, 16'hFFFF, "R6 modulus 2");
    run_op(16'd65534, 16'd65535, 16'h1235, "R6 base m-1");
    run_op(16'd2, 16'd3, 16'hAAAA, "R6 modulus 3");
    // R4/R7: pseudo-random operands
    for (int i = 0; i < 8; i++) begin
      logic [N-1:0] m, b;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      m = rng[15:0] | 16'h0002;
      b = N'(rng[31:16] % m);
      run_op(b, m, rng[23:8], "R4 random");
    end

    // R8: result held after done, done low
    repeat (5) @(negedge clk);
    check(result == last_exp, "R8 result held", result, last_exp);
    check(done == 1'b0, "R8 done low", done, 0);

    // R9: start while busy is ignored
    push_start(16'd77, 16'd50021, 16'h1357, "R9 ongoing op");
    repeat (60) @(negedge clk);
    check(busy == 1'b1, "R9 busy", busy, 1);
    base = 16'd5; modulus = 16'd7; exponent = 16'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (1500) @(negedge clk);
    check(n_seen == n_sent, "R9 single done", n_seen, n_sent);
    check(result == ref_pow(16'd77, 16'd50021, 16'h1357), "R9 result held",
          result, ref_pow(16'd77, 16'd50021, 16'h1357));
    summary();
  end
endmodule